// File: doc/BRIEF.md
# Receive-side PHY cell port for a 16-bit UTOPIA-style bus

This block sits at the PHY end of a receive cell bus. An internal producer pushes 16-bit cell words into a receive buffer that holds four cells. An ATM-layer reader drains the buffer one word per clock. It pulls an active-low read enable low to request words. The block answers with the data word, a start-of-cell marker and a data-bus output enable, which stands in for a tri-state driver. A cell is 54 bytes, which is 27 words numbered 0 to 26.

The cell-available flag can mean one of two things. In octet-level handshaking it is high whenever at least one word is buffered. In cell-level handshaking it is high only while at least one complete cell is buffered. A configuration pair selects the meaning: a multi-PHY strap and an octet-level request. Octet-level handshaking is honoured only in single-PHY configuration, and reset always starts in cell-level handshaking. If the reader keeps the enable low while the buffer is empty, it receives an invalid filler word. The position within the cell does not advance on such a read, so the cell resumes intact when data arrives.

Top module: `utopia_rx_phy`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs rx_data_oe_o, rx_soc_o, rx_clav_o and wr_full_o are 0 and ovf_count_o is 0.
- R2: Each cell is 27 words. rx_soc_o is 1 exactly in the cycle in which word 0 of a cell is on rx_data_o with rx_data_oe_o high. It is 0 for words 1 to 26 and for invalid words.
- R3: When rd_enb_n_i is sampled 0 at a rising edge and the buffer is not empty, the next buffered word appears on rx_data_o with rx_data_oe_o = 1 after that same edge.
- R4: In octet-level handshaking, rx_clav_o is 1 exactly when at least one word is buffered. It drops as soon as the buffer runs dry, even in mid-cell.
- R5: In cell-level handshaking, rx_clav_o is 1 exactly when at least one whole cell is buffered. The complete-cell count rises when word 26 is written and falls when word 26 is read.
- R6: Reset selects cell-level handshaking. Octet-level handshaking takes effect one cycle after octet_req_i = 1 with multi_phy_i = 0. With multi_phy_i = 1, cell-level handshaking is forced.
- R7: A read with rd_enb_n_i = 0 while the buffer is empty drives INVALID_WORD (default 16'hFFFF) with rx_data_oe_o = 1 and rx_soc_o = 0. The cell position does not advance.
- R8: When rd_enb_n_i is sampled 1, rx_data_oe_o is 0 after that edge. A later read continues with the next unread word of the same cell.
- R9: The buffer holds 108 words. wr_full_o is 1 at 108 words. A write while full is dropped, leaves the buffered data unchanged and raises ovf_count_o by one, saturating at all ones.
- R10: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| multi_phy_i | input | 1 | 1 = multi-PHY configuration (forces cell-level handshaking) |
| octet_req_i | input | 1 | 1 = request octet-level handshaking |
| wr_valid_i | input | 1 | Producer word strobe |
| wr_data_i | input | 16 | Producer word |
| wr_full_o | output | 1 | Buffer holds 108 words |
| ovf_count_o | output | 8 | Count of dropped writes, saturating |
| rd_enb_n_i | input | 1 | Reader enable, active low |
| rx_data_o | output | 16 | Word to the reader |
| rx_data_oe_o | output | 1 | Data bus driven (0 = high impedance) |
| rx_soc_o | output | 1 | Word 0 of a cell is on the bus |
| rx_clav_o | output | 1 | Cell-available flag |

## Verification
The assertions check several rules on every cycle:
- the one-cycle response of the bus enable to the read enable;
- start-of-cell appearing only while the bus is driven;
- filler words returned on reads from an empty buffer;
- forcing of cell-level handshaking under multi-PHY;
- the overflow counter stepping only on dropped writes;
- the flag being high whenever the buffer is full.

Only the bench scenarios can show the rest:
- the exact word order across a read pause and an underrun;
- the flag's two meanings over a whole cell;
- the start-of-cell marker moving to the next cell after 27 reads;
- the buffered contents surviving dropped writes.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

    localparam int unsigned RX_WORD_W = 16;

    typedef enum logic {
        HS_CELL  = 1'b0,
        HS_OCTET = 1'b1
    } hs_mode_e;

    typedef struct packed {
        logic                 oe;
        logic                 soc;
        logic [RX_WORD_W-1:0] data;
    } rx_bus_t;

    function automatic hs_mode_e pick_mode(input logic octet_req, input logic multi_phy);
        return (octet_req && !multi_phy) ? HS_OCTET : HS_CELL;
    endfunction

endpackage

// File: rtl/rx_word_fifo.sv
module rx_word_fifo import utopia_rx_pkg::*; #(
    parameter int unsigned DEPTH = 108
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  logic [RX_WORD_W-1:0] wdata,
    input  logic                 pop,
    output logic [RX_WORD_W-1:0] rdata,
    output logic                 empty,
    output logic                 full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [RX_WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]        wptr, rptr;
    logic [CW-1:0]        count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= (wptr == LAST_ADDR) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == LAST_ADDR) ? '0 : rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

endmodule

// File: rtl/rx_cell_tracker.sv
module rx_cell_tracker #(
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned FIFO_CELLS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    output logic first_word,
    output logic cells_nz
);
    localparam int unsigned PW  = $clog2(CELL_WORDS);
    localparam int unsigned CCW = $clog2(FIFO_CELLS + 1);
    localparam logic [PW-1:0] LAST_POS = PW'(CELL_WORDS - 1);

    logic [PW-1:0]  wr_pos, rd_pos;
    logic [CCW-1:0] cells;
    logic           wr_last, rd_last;

    assign wr_last = push && (wr_pos == LAST_POS);
    assign rd_last = pop  && (rd_pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pos <= '0;
            rd_pos <= '0;
            cells  <= '0;
        end else begin
            if (push) begin
                wr_pos <= wr_last ? '0 : wr_pos + 1'b1;
            end
            if (pop) begin
                rd_pos <= rd_last ? '0 : rd_pos + 1'b1;
            end
            case ({wr_last, rd_last})
                2'b10:   cells <= cells + 1'b1;
                2'b01:   cells <= cells - 1'b1;
                default: cells <= cells;
            endcase
        end
    end

    assign first_word = (rd_pos == '0);
    assign cells_nz   = (cells != '0);

endmodule

// File: rtl/rx_read_port.sv
module rx_read_port import utopia_rx_pkg::*; #(
    parameter logic [RX_WORD_W-1:0] INVALID_WORD = 16'hFFFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_enb_n,
    input  logic                 fifo_empty,
    input  logic [RX_WORD_W-1:0] fifo_rdata,
    input  logic                 first_word,
    output logic                 pop,
    output rx_bus_t              bus_q
);
    assign pop = !rd_enb_n && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= '0;
        end else if (rd_enb_n) begin
            bus_q <= '{oe: 1'b0, soc: 1'b0, data: '0};
        end else if (fifo_empty) begin
            bus_q <= '{oe: 1'b1, soc: 1'b0, data: INVALID_WORD};
        end else begin
            bus_q <= '{oe: 1'b1, soc: first_word, data: fifo_rdata};
        end
    end

endmodule

// File: rtl/utopia_rx_phy.sv
module utopia_rx_phy import utopia_rx_pkg::*; #(
    parameter int unsigned          CELL_WORDS   = 27,
    parameter int unsigned          FIFO_CELLS   = 4,
    parameter int unsigned          OVF_W        = 8,
    parameter logic [RX_WORD_W-1:0] INVALID_WORD = 16'hFFFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 multi_phy_i,
    input  logic                 octet_req_i,
    input  logic                 wr_valid_i,
    input  logic [RX_WORD_W-1:0] wr_data_i,
    output logic                 wr_full_o,
    output logic [OVF_W-1:0]     ovf_count_o,
    input  logic                 rd_enb_n_i,
    output logic [RX_WORD_W-1:0] rx_data_o,
    output logic                 rx_data_oe_o,
    output logic                 rx_soc_o,
    output logic                 rx_clav_o
);
    localparam int unsigned DEPTH = CELL_WORDS * FIFO_CELLS;

    hs_mode_e             mode_q;
    logic                 push, pop;
    logic                 fifo_empty, fifo_full;
    logic                 first_word, cells_nz;
    logic [RX_WORD_W-1:0] fifo_rdata;
    logic [OVF_W-1:0]     ovf_q;
    rx_bus_t              bus_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= HS_CELL;
        end else begin
            mode_q <= pick_mode(octet_req_i, multi_phy_i);
        end
    end

    assign push = wr_valid_i && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= '0;
        end else if (wr_valid_i && fifo_full && (ovf_q != '1)) begin
            ovf_q <= ovf_q + 1'b1;
        end
    end

    rx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (wr_data_i),
        .pop   (pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    rx_cell_tracker #(.CELL_WORDS(CELL_WORDS), .FIFO_CELLS(FIFO_CELLS)) u_cells (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .first_word (first_word),
        .cells_nz   (cells_nz)
    );

    rx_read_port #(.INVALID_WORD(INVALID_WORD)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_enb_n   (rd_enb_n_i),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .first_word (first_word),
        .pop        (pop),
        .bus_q      (bus_q)
    );

    always_comb begin
        unique case (mode_q)
            HS_OCTET: rx_clav_o = !fifo_empty;
            default:  rx_clav_o = cells_nz;
        endcase
    end

    assign wr_full_o    = fifo_full;
    assign ovf_count_o  = ovf_q;
    assign rx_data_o    = bus_q.data;
    assign rx_data_oe_o = bus_q.oe;
    assign rx_soc_o     = bus_q.soc;

endmodule

// File: rtl/utopia_rx_phy_chk.sv
module utopia_rx_phy_chk #(
    parameter int unsigned OVF_W        = 8,
    parameter logic [15:0] INVALID_WORD = 16'hFFFF
) (
    input logic             clk,
    input logic             rst,
    input logic             multi_phy_i,
    input logic             wr_valid_i,
    input logic             wr_full_o,
    input logic [OVF_W-1:0] ovf_count_o,
    input logic             rd_enb_n_i,
    input logic [15:0]      rx_data_o,
    input logic             rx_data_oe_o,
    input logic             rx_soc_o,
    input logic             rx_clav_o,
    input logic             mode_octet,
    input logic             fifo_empty
);
    // R2: start-of-cell only while the bus is driven
    a_r2_soc_with_oe: assert property (@(posedge clk) disable iff (rst)
        rx_soc_o |-> rx_data_oe_o);

    // R3: an enable sampled low drives the bus after that edge
    a_r3_enable_drives: assert property (@(posedge clk) disable iff (rst)
        !rd_enb_n_i |=> rx_data_oe_o);

    // R8: an enable sampled high releases the bus
    a_r8_release_bus: assert property (@(posedge clk) disable iff (rst)
        rd_enb_n_i |=> !rx_data_oe_o);

    // R7: an empty read returns the filler word, never a start-of-cell
    a_r7_filler_word: assert property (@(posedge clk) disable iff (rst)
        (!rd_enb_n_i && fifo_empty) |=> (rx_data_o == INVALID_WORD) && !rx_soc_o);

    // R6: multi-PHY keeps cell-level handshaking
    a_r6_multi_forces_cell: assert property (@(posedge clk) disable iff (rst)
        $past(multi_phy_i) |-> !mode_octet);

    // R9: a dropped write steps the overflow count
    a_r9_ovf_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && wr_full_o && (ovf_count_o != {OVF_W{1'b1}}))
        |=> ovf_count_o == OVF_W'($past(ovf_count_o) + 1'b1));

    // R9: without a dropped write the overflow count holds
    a_r9_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid_i && wr_full_o) |=> $stable(ovf_count_o));

    // R9: a full buffer always holds something to read
    a_r9_full_has_cell: assert property (@(posedge clk) disable iff (rst)
        wr_full_o |-> rx_clav_o);
endmodule

bind utopia_rx_phy utopia_rx_phy_chk #(.OVF_W(OVF_W), .INVALID_WORD(INVALID_WORD)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .multi_phy_i  (multi_phy_i),
    .wr_valid_i   (wr_valid_i),
    .wr_full_o    (wr_full_o),
    .ovf_count_o  (ovf_count_o),
    .rd_enb_n_i   (rd_enb_n_i),
    .rx_data_o    (rx_data_o),
    .rx_data_oe_o (rx_data_oe_o),
    .rx_soc_o     (rx_soc_o),
    .rx_clav_o    (rx_clav_o),
    .mode_octet   (mode_q == utopia_rx_pkg::HS_OCTET),
    .fifo_empty   (fifo_empty)
);

// File: tb/utopia_rx_phy_bench.sv
`timescale 1ns/1ps
module utopia_rx_phy_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        multi_phy_i = 1'b0;
    logic        octet_req_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        rd_enb_n_i = 1'b1;
    logic        wr_full_o;
    logic [7:0]  ovf_count_o;
    logic [15:0] rx_data_o;
    logic        rx_data_oe_o, rx_soc_o, rx_clav_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    utopia_rx_phy u_utopia_rx_phy (
        .clk(clk), .rst(rst), .multi_phy_i(multi_phy_i), .octet_req_i(octet_req_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_full_o(wr_full_o),
        .ovf_count_o(ovf_count_o), .rd_enb_n_i(rd_enb_n_i), .rx_data_o(rx_data_o),
        .rx_data_oe_o(rx_data_oe_o), .rx_soc_o(rx_soc_o), .rx_clav_o(rx_clav_o)
    );

    // {wr, rd_enb_n, exp_oe, exp_soc, exp_clav, exp_data}; octet-level walk
    localparam logic [20:0] VEC [0:11] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000},  // R4 one word buffered
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA000},  // R3 R2 word 0, dry again
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF},  // R7 underrun
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF},  // R7 push same edge
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hA001},  // R10 word 1
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000},  // R8 pause
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000},  // R8 pause
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA002},  // R8 resume word 2
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000},  // R4
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hA003},  // R10
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA004},  // R4 mid-cell drop
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000}   // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [15:0] wd, input logic rdn);
        wr_valid_i = wr;
        wr_data_i  = wd;
        rd_enb_n_i = rdn;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_valid_i = 1'b0;
        rd_enb_n_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, {28'd0, rx_data_oe_o, rx_soc_o, rx_clav_o, wr_full_o}, 32'd0);
        chk(tag, {24'd0, ovf_count_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int wseq;
        @(negedge clk);
        do_reset();
        chk_idle("R1 reset state");

        // octet-level table walk
        multi_phy_i = 1'b0;
        octet_req_i = 1'b1;
        cyc(1'b0, 16'h0, 1'b1);
        wseq = 0;
        for (int i = 0; i < 12; i++) begin
            logic [20:0] v;
            v = VEC[i];
            cyc(v[20], 16'hA000 + 16'(wseq), v[19]);
            if (v[20]) wseq++;
            chk($sformatf("R3/R8 oe vec%0d", i), {31'd0, rx_data_oe_o}, {31'd0, v[18]});
            chk($sformatf("R2 soc vec%0d", i), {31'd0, rx_soc_o}, {31'd0, v[17]});
            chk($sformatf("R4 clav vec%0d", i), {31'd0, rx_clav_o}, {31'd0, v[16]});
            if (v[18]) chk($sformatf("R10 R7 data vec%0d", i), {16'd0, rx_data_o}, {16'd0, v[15:0]});
        end

        // cell-level, forced by multi-PHY
        do_reset();
        chk_idle("R1 second reset");
        multi_phy_i = 1'b1;
        octet_req_i = 1'b1;
        for (int i = 0; i < 26; i++) begin
            cyc(1'b1, {8'h01, 8'(i)}, 1'b1);
            if (i == 0 || i == 25) chk("R5 R6 clav partial cell", {31'd0, rx_clav_o}, 32'd0);
        end
        cyc(1'b1, {8'h01, 8'd26}, 1'b1);
        chk("R5 clav whole cell", {31'd0, rx_clav_o}, 32'd1);
        for (int i = 0; i < 27; i++) begin
            cyc(1'b0, 16'h0, 1'b0);
            chk("R3 oe", {31'd0, rx_data_oe_o}, 32'd1);
            chk("R10 cell data", {16'd0, rx_data_o}, {16'h0001, 8'(i)});
            chk("R2 soc", {31'd0, rx_soc_o}, {31'd0, (i == 0)});
            chk("R5 clav during read", {31'd0, rx_clav_o}, {31'd0, (i < 26)});
        end
        cyc(1'b0, 16'h0, 1'b1);
        chk("R8 bus released", {31'd0, rx_data_oe_o}, 32'd0);

        // fill, overflow, then drain across a cell boundary
        do_reset();
        multi_phy_i = 1'b0;
        octet_req_i = 1'b0;
        cyc(1'b0, 16'h0, 1'b1);
        chk("R6 cell-level after reset", {31'd0, rx_clav_o}, 32'd0);
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 27; i++) begin
                cyc(1'b1, {8'(c), 8'(i)}, 1'b1);
            end
        end
        chk("R9 full at 108", {31'd0, wr_full_o}, 32'd1);
        chk("R9 no overflow yet", {24'd0, ovf_count_o}, 32'd0);
        for (int k = 0; k < 3; k++) cyc(1'b1, 16'hBAD0, 1'b1);
        chk("R9 overflow count", {24'd0, ovf_count_o}, 32'd3);
        chk("R9 still full", {31'd0, wr_full_o}, 32'd1);
        for (int n = 0; n < 28; n++) begin
            cyc(1'b0, 16'h0, 1'b0);
            chk("R9 R10 data kept", {16'd0, rx_data_o}, {16'd0, 8'(n / 27), 8'(n % 27)});
            chk("R2 soc per cell", {31'd0, rx_soc_o}, {31'd0, (n == 0 || n == 27)});
            if (n == 0) chk("R9 full clears", {31'd0, wr_full_o}, 32'd0);
        end
        cyc(1'b0, 16'h0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule